// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block produces a triangular offset that is added to the integer multiplier of a PLL feedback divider. Adding it spreads the output spectrum and lowers peak emissions. It runs on the reference clock seen after the feedback divider. Each reference cycle the offset moves by one programmed step, either up or down.

Software programs three values: a step size, a quarter-period count in reference cycles, and a spread type. The spread type is either centred on zero or below zero only. A lock input can protect these settings. While the lock is set, a write is stored only when the PLL reports power-down; at other times the write is dropped. The modulation runs only when the enable input is high and the PLL reports that it is active. Otherwise the offset is held at zero.

The offset is a signed two's-complement value with 15 fractional bits. The step is added at the least significant bit of the offset. The offset is a level that is valid in every cycle, so it has no handshake. All pins are plain control or status lines.

Top module: `ssm_gen`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `mod_offset` is 0 and `cur_step`, `cur_period` and `cur_down` are all 0.
- R2: Centre spread (`cur_down`=0) with quarter count P and step S. After the modulation starts, the offset rises by S on each of the first P clock edges and falls by S on each of the next 2P edges. It then rises by S on each of the next P edges, which brings it back to 0 after 4P edges. The pattern repeats. For example, with S=10 and P=4 the offset is 40 after 4 edges, 20 after 6, 0 after 8, -40 after 12, 0 after 16 and 40 after 20. With S=3 and P=1 it is -3 after 3 edges.
- R3: Down spread (`cur_down`=1). The offset falls by S on each of the first 2P edges, reaching -2·P·S, then rises by S on each of the next 2P edges back to 0. For example, with S=7 and P=3 it is -21 after 3 edges, -42 after 6, -21 after 9 and 0 after 12.
- R4: When `pll_active` is 0, `mod_offset` stays 0 even if `mod_en` is 1.
- R5: When `mod_en` drops to 0, `mod_offset` is 0 after the next clock edge.
- R6: When `cfg_lock`=1 and `pll_pd`=0, a `cfg_we` pulse leaves `cur_step`, `cur_period` and `cur_down` unchanged.
- R7: A `cfg_we` pulse stores `cfg_step`, `cfg_period` and `cfg_down` on the next edge in two cases: when `cfg_lock`=0, whatever the value of `pll_pd`, and when `cfg_lock`=1 and `pll_pd`=1.
- R8: While `cur_period` is 0, `mod_offset` stays 0 even when modulation is enabled.
- R9: The step is unsigned and the offset is a 32-bit signed sum that does not clip. With S=65535 and P=2, centre spread, the offset is 131070 after 2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock after the feedback divider |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the settings |
| cfg_lock | input | 1 | Lock: writes are accepted only during PLL power-down |
| pll_pd | input | 1 | PLL is in power-down |
| cfg_step | input | STEP_W | Step value to write |
| cfg_period | input | PER_W | Quarter-period count to write |
| cfg_down | input | 1 | Spread type to write: 0 = centre, 1 = down |
| mod_en | input | 1 | Modulation enable |
| pll_active | input | 1 | PLL is running |
| cur_step | output | STEP_W | Stored step |
| cur_period | output | PER_W | Stored quarter-period count |
| cur_down | output | 1 | Stored spread type |
| mod_offset | output | ACC_W | Signed offset, 15 fractional bits |

## Verification
The bench builds the block with its default widths: a 32-bit offset, a 16-bit step and a 14-bit quarter count. It drives small quarter counts of 1 to 4, so whole triangle periods, the turning points and the wrap back to zero all fall within a few dozen cycles. A full-scale 16-bit step shows that the offset grows past the step width without clipping. Zero quarter counts and changes to the lock and power-down inputs exercise the guard paths.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {SLOPE_UP = 1'b0, SLOPE_DN = 1'b1} slope_e;
  typedef enum logic {SPREAD_CENTER = 1'b0, SPREAD_DOWN = 1'b1} spread_e;
endpackage

// File: rtl/ssm_cfg_bank.sv
module ssm_cfg_bank
  import ssm_pkg::*;
#(
  parameter int STEP_W = 16,
  parameter int PER_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              lock_sel,
  input  logic              pll_pd,
  input  logic [STEP_W-1:0] step_i,
  input  logic [PER_W-1:0]  per_i,
  input  spread_e           spread_i,
  output logic [STEP_W-1:0] step_o,
  output logic [PER_W-1:0]  per_o,
  output spread_e           spread_o
);
  logic accept;

  // with the lock set, only a powered-down PLL may have its profile changed
  assign accept = we && (!lock_sel || pll_pd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_o   <= '0;
      per_o    <= '0;
      spread_o <= SPREAD_CENTER;
    end else if (accept) begin
      step_o   <= step_i;
      per_o    <= per_i;
      spread_o <= spread_i;
    end
  end

  assert_locked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock_sel && !pll_pd) |=> ($stable(step_o) && $stable(per_o) && $stable(spread_o)));
endmodule

// File: rtl/ssm_phase.sv
module ssm_phase
  import ssm_pkg::*;
#(
  parameter int PER_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] per,
  input  spread_e          spread,
  output slope_e           slope,
  output logic             live
);
  localparam int CNT_W = PER_W + 2;

  logic [CNT_W-1:0] q1, q2, q3, last, cnt_q;

  assign q1   = {2'b00, per};
  assign q2   = q1 << 1;
  assign q3   = q1 + q2;
  assign last = (q1 << 2) - 1'b1;
  assign live = (per != '0);

  // position within one triangle period of 4 quarters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run || !live)     cnt_q <= '0;
    else if (cnt_q >= last)     cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (spread == SPREAD_DOWN)
      slope = (cnt_q < q2) ? SLOPE_DN : SLOPE_UP;
    else
      slope = (cnt_q < q1 || cnt_q >= q3) ? SLOPE_UP : SLOPE_DN;
  end

  // the phase never leaves the programmed period (R2, R3)
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per != '0) |=> (cnt_q < ({2'b00, $past(per)} << 2)));
endmodule

// File: rtl/ssm_accum.sv
module ssm_accum
  import ssm_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int STEP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    live,
  input  slope_e                  slope,
  input  logic [STEP_W-1:0]       step,
  output logic signed [ACC_W-1:0] acc_q
);
  logic signed [ACC_W-1:0] step_ext;

  assign step_ext = $signed({{(ACC_W-STEP_W){1'b0}}, step});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              acc_q <= '0;
    else if (!run || !live)  acc_q <= '0;
    else if (slope == SLOPE_UP) acc_q <= acc_q + step_ext;
    else                     acc_q <= acc_q - step_ext;
  end

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == '0));
endmodule

// File: rtl/ssm_gen.sv
module ssm_gen
  import ssm_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int STEP_W = 16,
  parameter int PER_W  = 14
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic                    cfg_lock,
  input  logic                    pll_pd,
  input  logic [STEP_W-1:0]       cfg_step,
  input  logic [PER_W-1:0]        cfg_period,
  input  logic                    cfg_down,
  input  logic                    mod_en,
  input  logic                    pll_active,
  output logic [STEP_W-1:0]       cur_step,
  output logic [PER_W-1:0]        cur_period,
  output logic                    cur_down,
  output logic signed [ACC_W-1:0] mod_offset
);
  logic    run, live;
  spread_e spread_q;
  slope_e  slope;

  assign run      = mod_en && pll_active;
  assign cur_down = (spread_q == SPREAD_DOWN);

  ssm_cfg_bank #(.STEP_W(STEP_W), .PER_W(PER_W)) u_cfg (
    .clk(clk_ref), .rst_n(rst_n), .we(cfg_we), .lock_sel(cfg_lock),
    .pll_pd(pll_pd), .step_i(cfg_step), .per_i(cfg_period),
    .spread_i(spread_e'(cfg_down)), .step_o(cur_step), .per_o(cur_period),
    .spread_o(spread_q)
  );

  ssm_phase #(.PER_W(PER_W)) u_phase (
    .clk(clk_ref), .rst_n(rst_n), .run(run), .per(cur_period),
    .spread(spread_q), .slope(slope), .live(live)
  );

  ssm_accum #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
    .clk(clk_ref), .rst_n(rst_n), .run(run), .live(live), .slope(slope),
    .step(cur_step), .acc_q(mod_offset)
  );

  // every running edge moves the offset by exactly one stored step
  assert_step_move_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(rst_n) && $past(run) && ($past(cur_period) != '0)) |->
      ((mod_offset - $past(mod_offset)) == $signed({{(ACC_W-STEP_W){1'b0}}, $past(cur_step)}) ||
       ($past(mod_offset) - mod_offset) == $signed({{(ACC_W-STEP_W){1'b0}}, $past(cur_step)})));
endmodule

// File: tb/ssm_gen_bench.sv
module ssm_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam int V_DOWN[NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
  localparam int V_STEP[NV] = '{10, 10, 10, 10, 10, 10, 7, 7, 7, 7, 65535, 3};
  localparam int V_PER [NV] = '{4, 4, 4, 4, 4, 4, 3, 3, 3, 3, 2, 1};
  localparam int V_N   [NV] = '{4, 6, 8, 12, 16, 20, 3, 6, 9, 12, 2, 3};
  localparam int V_EXP [NV] = '{40, 20, 0, -40, 0, 40, -21, -42, -21, 0, 131070, -3};

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_lock = 0, pll_pd = 0, cfg_down = 0, mod_en = 0, pll_active = 0;
  logic [15:0] cfg_step = '0;
  logic [13:0] cfg_period = '0;
  logic [15:0] cur_step;
  logic [13:0] cur_period;
  logic cur_down;
  logic signed [31:0] mod_offset;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssm_gen u_ssm_gen (
    .clk_ref(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lock(cfg_lock), .pll_pd(pll_pd),
    .cfg_step(cfg_step), .cfg_period(cfg_period), .cfg_down(cfg_down), .mod_en(mod_en),
    .pll_active(pll_active), .cur_step(cur_step), .cur_period(cur_period),
    .cur_down(cur_down), .mod_offset(mod_offset)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input int dn, input int st, input int pr);
    @(negedge clk);
    cfg_down = dn[0]; cfg_step = st[15:0]; cfg_period = pr[13:0]; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 offset in reset", mod_offset, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 offset after reset", mod_offset, 0);
    chk("R1 step after reset", cur_step, 0);
    chk("R1 period/down after reset", {cur_down, cur_period}, 0);
    pll_active = 1;

    for (int i = 0; i < NV; i++) begin
      write_cfg(V_DOWN[i], V_STEP[i], V_PER[i]);
      mod_en = 1;
      repeat (V_N[i]) @(posedge clk);
      @(negedge clk);
      chk($sformatf("%s vector %0d", (i == 10) ? "R9" : (V_DOWN[i] != 0 ? "R3" : "R2"), i),
          mod_offset, V_EXP[i]);
      mod_en = 0;
      @(negedge clk);
    end

    // R4: enable request while PLL inactive
    write_cfg(0, 5, 4);
    pll_active = 0; mod_en = 1;
    repeat (5) @(negedge clk);
    chk("R4 inactive pll", mod_offset, 0);
    pll_active = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R4 resumes when active", mod_offset, 15);
    // R5: clearing enable
    mod_en = 0;
    @(negedge clk);
    chk("R5 clear enable", mod_offset, 0);

    // R8: zero quarter count
    write_cfg(0, 9, 0);
    mod_en = 1;
    repeat (5) @(negedge clk);
    chk("R8 zero period", mod_offset, 0);
    mod_en = 0;

    // R6: locked, PLL running
    write_cfg(0, 11, 3);
    cfg_lock = 1; pll_pd = 0;
    write_cfg(1, 99, 7);
    chk("R6 locked step", cur_step, 11);
    chk("R6 locked period/down", {cur_down, cur_period}, 3);
    // R7: locked but powered down
    pll_pd = 1;
    write_cfg(1, 99, 7);
    chk("R7 pd write step", cur_step, 99);
    chk("R7 pd write period/down", {cur_down, cur_period}, {1'b1, 14'd7});
    // R7: unlocked, PLL running
    cfg_lock = 0; pll_pd = 0;
    write_cfg(0, 44, 2);
    chk("R7 unlocked write", cur_step, 44);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule